// File: doc/BRIEF.md
# Thermal Sensor Sampling Rate Controller

This block turns a digital temperature reading into three trip flags: catastrophic, hot and auxiliary. A 4-bit mode field chooses between two ways of working.

- **Continuous analog mode.** The field is zero, or holds an unused code. When the sensor enable is high, the block compares every clock. Only the catastrophic and hot flags are live. The hot level is taken as the catastrophic threshold less a programmed offset.
- **Timed measurement mode.** The field holds a valid code. The block counts out a measurement cycle of a selected number of clocks. At the last clock of each cycle it compares the reading against the catastrophic, hot and auxiliary thresholds, which are programmed separately. It holds the result until the next cycle ends and pulses a done strobe for each completed cycle.

Software programs the mode and the thresholds through a small write port. A lock input freezes the mode field. A running cycle always finishes, even when the mode field is cleared or changed while the cycle is in progress. The new setting is used from the next cycle on.

Top module: `thermo_sampler`

## Requirements
- R1: After reset the mode field is 0 (continuous analog mode), all three trip flags are low and `cycle_done` is low.
- R2: Mode codes select the cycle length as a multiple of `BASE_LEN` (default 512) clocks: 1→1×, 2→2×, 3→3×, 4→4×, 5→6×, 6→8×, 7→12×. Code 15 selects `TEST_LEN` (default 4) clocks. Consecutive done pulses are exactly one cycle length apart.
- R3: Codes 8 to 14 start no cycle and produce no done pulse. The block behaves as in continuous analog mode.
- R4: When the mode field is cleared during a cycle, that cycle completes with one more done pulse. After that no further pulse occurs.
- R5: While `lock` is high, writes to the mode field (`cfg_sel`=0, `cfg_wdata[3:0]`) are ignored. Threshold writes still take effect.
- R6: In timed mode, at each cycle end each flag is set when the reading is greater than or equal to its own threshold: catastrophic (`cfg_sel`=1), hot (`cfg_sel`=2), auxiliary (`cfg_sel`=3). The flags hold their value until the next cycle end.
- R7: In continuous analog mode with `sens_en` high, the flags are registered one clock after the reading. Catastrophic is set when the reading is at or above the catastrophic threshold. Hot is set when the reading is at or above the catastrophic threshold minus the offset (`cfg_sel`=4), with that difference floored at 0. Auxiliary stays low. With `sens_en` low, all flags are low.
- R8: `cycle_done` is high for exactly one clock per completed cycle, in the clock after the cycle's last count. The flags update in the same clock.
- R9: A mode code written during a cycle does not alter that cycle's length. The new length applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 catastrophic, 2 hot, 3 auxiliary, 4 hot offset |
| cfg_wdata | input | TEMP_W | Write data (mode uses bits 3:0) |
| lock | input | 1 | Freezes the mode field while high |
| sens_en | input | 1 | Sensor enable for continuous analog mode |
| temp_in | input | TEMP_W | Digital temperature reading |
| cat_trip | output | 1 | Catastrophic trip flag |
| hot_trip | output | 1 | Hot trip flag |
| aux_trip | output | 1 | Auxiliary trip flag |
| cycle_done | output | 1 | One-clock strobe at each completed cycle |

## Verification
The hardest case to reach from the ports is a mode write that lands partway through a running cycle, whether it changes the code, clears it, or is blocked by the lock. The stimulus counts clocks from an observed done pulse and issues the write at a known offset inside the cycle. It then measures the distance to the next one or two done pulses. This separates the finishing cycle from the one that follows. The flag results are queued by a driver at a known offset after each pulse. A monitor matches them against the flags it sees at the next pulse.

// File: rtl/therm_pkg.sv
package therm_pkg;
    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_CAT  = 3'd1;
    localparam logic [2:0] SEL_HOT  = 3'd2;
    localparam logic [2:0] SEL_AUX  = 3'd3;
    localparam logic [2:0] SEL_OFF  = 3'd4;

    localparam logic [3:0] MODE_TEST = 4'hF;

    // Length multiple of the base period for codes 1..7, zero otherwise.
    function automatic int unsigned mode_mult(input logic [3:0] code);
        case (code)
            4'd1:    return 1;
            4'd2:    return 2;
            4'd3:    return 3;
            4'd4:    return 4;
            4'd5:    return 6;
            4'd6:    return 8;
            4'd7:    return 12;
            default: return 0;
        endcase
    endfunction

    function automatic logic mode_is_timed(input logic [3:0] code);
        return (mode_mult(code) != 0) || (code == MODE_TEST);
    endfunction
endpackage

// File: rtl/therm_cfg_regs.sv
module therm_cfg_regs
    import therm_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [TEMP_W-1:0] wdata,
    input  logic              lock,
    output logic [3:0]        mode,
    output logic [TEMP_W-1:0] cat_thr,
    output logic [TEMP_W-1:0] hot_thr,
    output logic [TEMP_W-1:0] aux_thr,
    output logic [TEMP_W-1:0] hot_off
);
    typedef struct packed {
        logic [3:0]        mode;
        logic [TEMP_W-1:0] cat;
        logic [TEMP_W-1:0] hot;
        logic [TEMP_W-1:0] aux;
        logic [TEMP_W-1:0] off;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                SEL_MODE: if (!lock) cfg_d.mode = wdata[3:0];
                SEL_CAT:  cfg_d.cat = wdata;
                SEL_HOT:  cfg_d.hot = wdata;
                SEL_AUX:  cfg_d.aux = wdata;
                SEL_OFF:  cfg_d.off = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode    = cfg_q.mode;
    assign cat_thr = cfg_q.cat;
    assign hot_thr = cfg_q.hot;
    assign aux_thr = cfg_q.aux;
    assign hot_off = cfg_q.off;
endmodule

// File: rtl/therm_mode_decode.sv
module therm_mode_decode
    import therm_pkg::*;
#(
    parameter int BASE_LEN = 512,
    parameter int TEST_LEN = 4,
    parameter int CNT_W    = 13
) (
    input  logic [3:0]       mode,
    output logic             timed,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        timed = mode_is_timed(mode);
        if (mode == MODE_TEST) len = CNT_W'(TEST_LEN);
        else                   len = CNT_W'(mode_mult(mode) * BASE_LEN);
    end
endmodule

// File: rtl/therm_cycle_timer.sv
module therm_cycle_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timed,
    input  logic [CNT_W-1:0] sel_len,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] len,
    output logic             cyc_end
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last_d;

    always_comb begin
        t_d    = t_q;
        last_d = t_q.run && (t_q.cnt == t_q.len - 1'b1);
        if (!t_q.run || last_d) begin
            // Start (or restart) only on a timed code; length latched here.
            t_d.run = timed;
            t_d.cnt = '0;
            t_d.len = timed ? sel_len : t_q.len;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign run     = t_q.run;
    assign cnt     = t_q.cnt;
    assign len     = t_q.len;
    assign cyc_end = last_d;
endmodule

// File: rtl/therm_trip_eval.sv
module therm_trip_eval #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cyc_end,
    input  logic              sens_en,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] cat_thr,
    input  logic [TEMP_W-1:0] hot_thr,
    input  logic [TEMP_W-1:0] aux_thr,
    input  logic [TEMP_W-1:0] hot_off,
    output logic              cat,
    output logic              hot,
    output logic              aux,
    output logic              done
);
    typedef struct packed {
        logic cat;
        logic hot;
        logic aux;
        logic done;
    } trip_t;

    trip_t r_d, r_q;
    logic [TEMP_W-1:0] an_hot_thr;

    always_comb begin
        an_hot_thr = (hot_off > cat_thr) ? '0 : (cat_thr - hot_off);
        r_d        = r_q;
        r_d.done   = cyc_end;
        if (cyc_end) begin
            r_d.cat = (temp >= cat_thr);
            r_d.hot = (temp >= hot_thr);
            r_d.aux = (temp >= aux_thr);
        end else if (!run) begin
            r_d.cat = sens_en && (temp >= cat_thr);
            r_d.hot = sens_en && (temp >= an_hot_thr);
            r_d.aux = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cat  = r_q.cat;
    assign hot  = r_q.hot;
    assign aux  = r_q.aux;
    assign done = r_q.done;
endmodule

// File: rtl/thermo_sampler.sv
module thermo_sampler #(
    parameter int TEMP_W   = 8,
    parameter int BASE_LEN = 512,
    parameter int TEST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [TEMP_W-1:0] cfg_wdata,
    input  logic              lock,
    input  logic              sens_en,
    input  logic [TEMP_W-1:0] temp_in,
    output logic              cat_trip,
    output logic              hot_trip,
    output logic              aux_trip,
    output logic              cycle_done
);
    localparam int MAX_LEN = (12 * BASE_LEN > TEST_LEN) ? 12 * BASE_LEN : TEST_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [3:0]        mode_q;
    logic [TEMP_W-1:0] cat_thr, hot_thr, aux_thr, hot_off;
    logic              mode_timed;
    logic [CNT_W-1:0]  mode_len;
    logic              tmr_run, tmr_end;
    logic [CNT_W-1:0]  tmr_cnt, tmr_len;

    therm_cfg_regs #(.TEMP_W(TEMP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .lock(lock), .mode(mode_q), .cat_thr(cat_thr), .hot_thr(hot_thr),
        .aux_thr(aux_thr), .hot_off(hot_off)
    );

    therm_mode_decode #(.BASE_LEN(BASE_LEN), .TEST_LEN(TEST_LEN), .CNT_W(CNT_W)) u_dec (
        .mode(mode_q), .timed(mode_timed), .len(mode_len)
    );

    therm_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .timed(mode_timed), .sel_len(mode_len),
        .run(tmr_run), .cnt(tmr_cnt), .len(tmr_len), .cyc_end(tmr_end)
    );

    therm_trip_eval #(.TEMP_W(TEMP_W)) u_trip (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .cyc_end(tmr_end),
        .sens_en(sens_en), .temp(temp_in), .cat_thr(cat_thr), .hot_thr(hot_thr),
        .aux_thr(aux_thr), .hot_off(hot_off), .cat(cat_trip), .hot(hot_trip),
        .aux(aux_trip), .done(cycle_done)
    );
endmodule

// File: rtl/thermo_sampler_chk.sv
module thermo_sampler_chk #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_sel,
    input logic             lock,
    input logic [3:0]       mode_q,
    input logic             mode_timed,
    input logic             tmr_run,
    input logic             tmr_end,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [CNT_W-1:0] tmr_len,
    input logic             cat_trip,
    input logic             hot_trip,
    input logic             aux_trip,
    input logic             cycle_done
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    assert_done_from_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> $past(tmr_run));

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> (tmr_cnt < tmr_len));

    assert_len_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && !tmr_end) |=> $stable(tmr_len));

    assert_cycle_finishes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && !tmr_end) |=> tmr_run);

    assert_reserved_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_run && !mode_timed) |=> !tmr_run);

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && cfg_we && cfg_sel == 3'd0) |=> $stable(mode_q));

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && !tmr_end) |=> $stable({cat_trip, hot_trip, aux_trip}));

    assert_aux_analog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_run |=> !aux_trip);
endmodule

bind thermo_sampler thermo_sampler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .lock(lock),
    .mode_q(mode_q), .mode_timed(mode_timed), .tmr_run(tmr_run), .tmr_end(tmr_end),
    .tmr_cnt(tmr_cnt), .tmr_len(tmr_len), .cat_trip(cat_trip), .hot_trip(hot_trip),
    .aux_trip(aux_trip), .cycle_done(cycle_done)
);

// File: tb/tb_thermo_sampler.sv
`timescale 1ns/1ps
module tb_thermo_sampler;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_sel = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic         lock = 1'b0;
    logic         sens_en = 1'b0;
    logic [W-1:0] temp_in = '0;
    logic         cat_trip, hot_trip, aux_trip, cycle_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct { logic [2:0] flags; string req; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    thermo_sampler dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lock(lock), .sens_en(sens_en), .temp_in(temp_in),
        .cat_trip(cat_trip), .hot_trip(hot_trip), .aux_trip(aux_trip),
        .cycle_done(cycle_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Returns at the negedge where cycle_done is seen; n counts negedges waited.
    task automatic wait_done(input int max, output bit seen, output int n);
        seen = 1'b0; n = 0;
        while (n < max && !seen) begin
            @(negedge clk);
            n++;
            if (cycle_done) seen = 1'b1;
        end
    endtask

    function automatic logic [2:0] flags3();
        return {cat_trip, hot_trip, aux_trip};
    endfunction

    // Monitor: compares queued expectations at each done pulse.
    always @(negedge clk) begin
        if (rst_n && cycle_done && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(flags3() == e.flags, e.req, int'(flags3()), int'(e.flags));
        end
    end

    initial begin
        #700000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        bit seen;
        int n;
        int lens[7] = '{512, 1024, 1536, 2048, 3072, 4096, 6144};
        logic [W-1:0] tv[6] = '{8'd50, 8'd65, 8'd85, 8'd120, 8'd100, 8'd99};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(flags3() == 3'b000, "R1 flags after reset", int'(flags3()), 0);
        chk(cycle_done == 1'b0, "R1 done after reset", int'(cycle_done), 0);
        wait_done(50, seen, n);
        chk(!seen, "R1 no cycle in default mode", int'(seen), 0);

        // R7: continuous analog mode
        sens_en = 1'b1;
        wr(3'd1, 8'd100);
        wr(3'd4, 8'd30);
        wr(3'd3, 8'd0);
        temp_in = 8'd69; @(negedge clk);
        chk(flags3() == 3'b000, "R7 analog below hot", int'(flags3()), 0);
        temp_in = 8'd70; @(negedge clk);
        chk(flags3() == 3'b010, "R7 analog hot edge", int'(flags3()), 2);
        temp_in = 8'd100; @(negedge clk);
        chk(flags3() == 3'b110, "R7 analog cat edge, aux off", int'(flags3()), 6);
        sens_en = 1'b0; @(negedge clk);
        chk(flags3() == 3'b000, "R7 sensor disabled", int'(flags3()), 0);
        sens_en = 1'b1;
        wr(3'd4, 8'd200);
        temp_in = 8'd0; @(negedge clk);
        chk(flags3() == 3'b010, "R7 offset floor at zero", int'(flags3()), 2);

        // R3: reserved codes stay in analog mode
        wr(3'd0, 8'h08);
        temp_in = 8'd150; @(negedge clk);
        chk(flags3() == 3'b110, "R3 reserved acts analog", int'(flags3()), 6);
        wait_done(300, seen, n);
        chk(!seen, "R3 code 8 no cycle", int'(seen), 0);
        wr(3'd0, 8'h0E);
        wait_done(300, seen, n);
        chk(!seen, "R3 code 14 no cycle", int'(seen), 0);

        // R2: cycle lengths; R9: new code takes effect after current cycle
        for (int i = 0; i < 7; i++) begin
            wr(3'd0, 8'(i + 1));
            wait_done(7000, seen, n);
            wait_done(7000, seen, n);
            chk(seen && n == lens[i], $sformatf("R2 code %0d length", i + 1), n, lens[i]);
        end
        wr(3'd0, 8'h0F);
        wait_done(7000, seen, n);
        chk(seen && n <= 6144, "R9 old length finishes first", n, 6144);
        wait_done(100, seen, n);
        chk(seen && n == 4, "R2 test code length", n, 4);
        @(negedge clk);
        chk(cycle_done == 1'b0, "R8 done lasts one clock", int'(cycle_done), 0);
        wr(3'd0, 8'h01);
        wait_done(100, seen, n);
        chk(seen && n <= 4, "R9 short cycle completes", n, 4);
        wait_done(1000, seen, n);
        chk(seen && n == 512, "R9 new length next cycle", n, 512);

        // R6: timed-mode comparisons through the scoreboard
        wr(3'd0, 8'h0F);
        wr(3'd1, 8'd100);
        wr(3'd2, 8'd80);
        wr(3'd3, 8'd60);
        wait_done(1000, seen, n);
        wait_done(100, seen, n);
        foreach (tv[k]) begin
            exp_t e;
            wait_done(100, seen, n);
            @(posedge clk); #1;
            temp_in = tv[k];
            e.flags = {tv[k] >= 8'd100, tv[k] >= 8'd80, tv[k] >= 8'd60};
            e.req = $sformatf("R6 temp %0d", tv[k]);
            sb_q.push_back(e);
        end
        wait_done(100, seen, n);
        @(negedge clk);
        chk(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);

        // R5: lock freezes mode, thresholds stay writable
        lock = 1'b1;
        wr(3'd0, 8'h01);
        wr(3'd1, 8'd10);
        wait_done(100, seen, n);
        wait_done(100, seen, n);
        chk(seen && n == 4, "R5 locked mode unchanged", n, 4);
        temp_in = 8'd20;
        wait_done(100, seen, n);
        wait_done(100, seen, n);
        chk(cat_trip == 1'b1, "R5 threshold write under lock", int'(cat_trip), 1);
        lock = 1'b0;

        // R4: clearing the mode mid-cycle lets the cycle finish
        wr(3'd0, 8'h01);
        wait_done(1000, seen, n);
        wait_done(1000, seen, n);
        repeat (100) @(negedge clk);
        wr(3'd0, 8'h00);
        wait_done(1000, seen, n);
        chk(seen && n <= 412, "R4 running cycle completes", n, 410);
        wait_done(2000, seen, n);
        chk(!seen, "R4 no cycle after finish", int'(seen), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule